// File: doc/BRIEF.md
# Attribute-aware pixel serializer

This block turns fetched screen bytes into a scanline of 640 colour indices, one per cycle of the pixel clock. A byte of bitmap data covers eight pixels. Each pixel can be held for one, two or three cycles, which gives 80, 40 or 26 character columns across the line. In the tripled mode the 26 columns fill 624 cycles, and the line is padded to 640 with blank pixels.

In the doubled and tripled modes not every byte fetch slot is needed for bitmap data. A spare slot inside each column can fetch an attribute byte for the column that follows. That byte sets the foreground colour, used for bitmap bits of 1, and the background colour, used for bits of 0. An attribute byte can cover one character, or two characters with a nibble each. Attributes are fetched only on the first pixel row of a character row. They are kept in a column-indexed buffer and reused on the other rows.

Each line starts with a pulse on `line_start`. The mode inputs are sampled on that pulse. Eight dark lead-in cycles follow, which give time to fetch the first column's attribute and bitmap bytes. The block drives one request at a time towards memory and takes the byte on `fetch_data` in the cycle the request is shown.

Top module: `attr_pixel_serializer`

## Requirements
- R1: An accepted `line_start` is followed by 8 cycles with `pix_valid`=0, then exactly 640 consecutive cycles with `pix_valid`=1, after which `pix_valid` returns to 0.
- R2: With `scale_sel`=0 (x1) there are 80 columns and one pixel per cycle. Bits shift out most significant bit first. Without attributes the colour index is 1 for a bit of 1 and 0 for a bit of 0.
- R3: `scale_sel`=1 (x2) holds each pixel for 2 cycles over 40 columns. `scale_sel`=2 (x3) holds each pixel for 3 cycles over 26 columns. `scale_sel`=3 behaves as x1.
- R4: In x3 the last 16 valid cycles of a line have `pix_blank`=1 and `pix_color`=0. In x1 and x2 `pix_blank` stays 0.
- R5: There is one bitmap request (`fetch_attr`=0) per column, in column order, with `fetch_col` equal to the column. The byte on `fetch_data` is taken in the cycle `fetch_req` is 1. No two requests are in consecutive cycles, and there are at most 80 requests per line.
- R6: With `attr_mode`=1 (full byte) in x2 or x3 on a first-row line, there is one attribute request (`fetch_attr`=1) per column. The foreground is attr[7:4] and the background is attr[3:0].
- R7: With `attr_mode`=2 (shared) in x2 or x3 on a first-row line, attribute requests are made only for even columns. An even column uses attr[7:4] and the following odd column uses attr[3:0]. In the selected nibble, bits [3:2] give the foreground index and bits [1:0] give the background index, with the upper bits of the index set to zero.
- R8: With `first_row`=0 no attribute requests are made. Each column takes its colours from the bytes stored on the most recent first-row line that fetched attributes.
- R9: In x1, any value of `attr_mode` produces no attribute requests and gives the colours of R2. `attr_mode`=0 and 3 also use the colours of R2.
- R10: `scale_sel`, `attr_mode` and `first_row` are sampled only on an accepted `line_start`. A `line_start` while a line is in progress is ignored.
- R11: While `rst_n`=0, `pix_valid`, `pix_blank`, `fetch_req` and `pix_color` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Start a scanline (accepted only when idle) |
| scale_sel | input | 2 | 0: x1, 1: x2, 2: x3, 3: x1 |
| attr_mode | input | 2 | 0: none, 1: full byte per column, 2: nibble per column pair, 3: none |
| first_row | input | 1 | This line is the first pixel row of a character row |
| fetch_req | output | 1 | Memory byte request |
| fetch_attr | output | 1 | Request kind: 1 attribute, 0 bitmap |
| fetch_col | output | 7 | Column the request is for |
| fetch_data | input | 8 | Requested byte, valid while fetch_req is 1 |
| pix_valid | output | 1 | A pixel value is on pix_color |
| pix_blank | output | 1 | Current pixel is line padding |
| pix_color | output | 4 | Colour index |

## Verification
On every cycle the assertions check a few rules. Each line delivers 640 valid cycles. A blank pixel is always valid and colourless. Memory requests never come back to back and stay within 80 per line. Attribute requests stay inside the buffer and, in shared mode, go only to even columns. Only the bench's scenarios can show that the colour of each pixel is right. This covers the bit order and the pixel repetition, the nibble split, and the reuse of stored attributes on later rows even when memory holds different values. It also covers the mid-line `line_start` and mode changes that must have no effect.

// File: rtl/aps_pkg.sv
package aps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_ACT  = 2'd2,
        ST_PAD  = 2'd3
    } aps_state_e;

    typedef enum logic [1:0] {
        AM_NONE   = 2'd0,
        AM_FULL   = 2'd1,
        AM_SHARED = 2'd2,
        AM_RSVD   = 2'd3
    } aps_amode_e;

    // Convert the scale select code into a repeat factor (1..3).
    function automatic logic [1:0] scale_factor(input logic [1:0] code);
        case (code)
            2'd1:    return 2'd2;
            2'd2:    return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/aps_attr_buf.sv
module aps_attr_buf #(
    parameter int DEPTH = 40,
    parameter int AW    = 7,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] ent_d;
        always_comb begin
            ent_d = ent_q[i];
            if (we && (waddr == AW'(i))) ent_d = wdata;
        end
        always_ff @(posedge clk) begin
            ent_q[i] <= ent_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (raddr == AW'(j)) rdata = ent_q[j];
        end
    end

endmodule

// File: rtl/aps_color_sel.sv
module aps_color_sel #(
    parameter int COLOR_W = 4
) (
    input  logic [7:0]         attr,
    input  logic               attr_on,
    input  logic               shared,
    input  logic               odd,
    output logic [COLOR_W-1:0] fg,
    output logic [COLOR_W-1:0] bg
);

    logic [3:0] nib;

    always_comb begin
        nib = odd ? attr[3:0] : attr[7:4];
        if (!attr_on) begin
            fg = COLOR_W'(1);
            bg = '0;
        end else if (shared) begin
            fg = COLOR_W'(nib[3:2]);
            bg = COLOR_W'(nib[1:0]);
        end else begin
            fg = COLOR_W'(attr[7:4]);
            bg = COLOR_W'(attr[3:0]);
        end
    end

endmodule

// File: rtl/attr_pixel_serializer.sv
module attr_pixel_serializer
    import aps_pkg::*;
#(
    parameter int LINE_PIX = 640,
    parameter int LEAD_CYC = 8,
    parameter int COLOR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic [1:0]         scale_sel,
    input  logic [1:0]         attr_mode,
    input  logic               first_row,
    output logic               fetch_req,
    output logic               fetch_attr,
    output logic [6:0]         fetch_col,
    input  logic [7:0]         fetch_data,
    output logic               pix_valid,
    output logic               pix_blank,
    output logic [COLOR_W-1:0] pix_color
);

    localparam int BYTE_PIX   = 8;
    localparam int COLS1      = LINE_PIX / BYTE_PIX;
    localparam int COLS2      = LINE_PIX / (2 * BYTE_PIX);
    localparam int COLS3      = LINE_PIX / (3 * BYTE_PIX);
    localparam int PAD3       = LINE_PIX - COLS3 * 3 * BYTE_PIX;
    localparam int ABUF_DEPTH = COLS2;
    localparam int COL_W      = 7;
    localparam int SEG_MAX    = (LEAD_CYC > 3 * BYTE_PIX) ? LEAD_CYC : 3 * BYTE_PIX;
    localparam int CNT_MAX    = (PAD3 > SEG_MAX) ? PAD3 : SEG_MAX;
    localparam int PH_W       = $clog2(CNT_MAX + 1);
    localparam int MAX_FETCH  = LINE_PIX / BYTE_PIX;

    typedef struct packed {
        aps_state_e         st;
        logic [PH_W-1:0]    phase;
        logic [1:0]         sub;
        logic [COL_W-1:0]   col;
        logic [7:0]         bmp_cur;
        logic [7:0]         bmp_next;
        logic [COLOR_W-1:0] fg;
        logic [COLOR_W-1:0] bg;
        logic [1:0]         scale;
        aps_amode_e         amode;
        logic               first;
        logic               req;
        logic               req_attr;
        logic [COL_W-1:0]   req_col;
    } ser_t;

    ser_t q, d;

    logic               active_seg, attr_on, shared, more;
    logic               want_attr, want_bmp;
    logic [PH_W-1:0]    seg_last;
    logic [COL_W-1:0]   nxt, cols_cur, raddr;
    logic [7:0]         attr_rd;
    logic [COLOR_W-1:0] fg_sel, bg_sel;

    aps_attr_buf #(.DEPTH(ABUF_DEPTH), .AW(COL_W), .DW(8)) u_buf (
        .clk   (clk),
        .we    (q.req && q.req_attr),
        .waddr (q.req_col),
        .wdata (fetch_data),
        .raddr (raddr),
        .rdata (attr_rd)
    );

    aps_color_sel #(.COLOR_W(COLOR_W)) u_csel (
        .attr    (attr_rd),
        .attr_on (attr_on),
        .shared  (shared),
        .odd     (nxt[0]),
        .fg      (fg_sel),
        .bg      (bg_sel)
    );

    always_comb begin
        active_seg = (q.st == ST_LEAD) || (q.st == ST_ACT);
        attr_on    = ((q.amode == AM_FULL) || (q.amode == AM_SHARED)) && (q.scale != 2'd1);
        shared     = (q.amode == AM_SHARED);
        nxt        = (q.st == ST_LEAD) ? '0 : q.col + 1'b1;
        case (q.scale)
            2'd2:    begin seg_last = PH_W'(2 * BYTE_PIX - 1); cols_cur = COL_W'(COLS2); end
            2'd3:    begin seg_last = PH_W'(3 * BYTE_PIX - 1); cols_cur = COL_W'(COLS3); end
            default: begin seg_last = PH_W'(BYTE_PIX - 1);     cols_cur = COL_W'(COLS1); end
        endcase
        if (q.st == ST_LEAD) seg_last = PH_W'(LEAD_CYC - 1);
        more      = (nxt < cols_cur);
        raddr     = shared ? {nxt[COL_W-1:1], 1'b0} : nxt;
        want_attr = active_seg && (q.phase == PH_W'(1)) && attr_on && q.first && more
                    && (!shared || !nxt[0]);
        want_bmp  = active_seg && (q.phase == seg_last - PH_W'(2)) && more;
    end

    always_comb begin
        d          = q;
        d.req      = want_attr || want_bmp;
        d.req_attr = want_attr;
        d.req_col  = nxt;
        if (q.req && !q.req_attr) d.bmp_next = fetch_data;
        case (q.st)
            ST_IDLE: begin
                if (line_start) begin
                    d.st    = ST_LEAD;
                    d.phase = '0;
                    d.scale = scale_factor(scale_sel);
                    d.amode = aps_amode_e'(attr_mode);
                    d.first = first_row;
                end
            end
            ST_LEAD: begin
                d.phase = q.phase + 1'b1;
                if (q.phase == seg_last) begin
                    d.st      = ST_ACT;
                    d.phase   = '0;
                    d.sub     = '0;
                    d.col     = '0;
                    d.bmp_cur = q.bmp_next;
                    d.fg      = fg_sel;
                    d.bg      = bg_sel;
                end
            end
            ST_ACT: begin
                d.phase = q.phase + 1'b1;
                if (q.sub == q.scale - 2'd1) begin
                    d.sub     = '0;
                    d.bmp_cur = {q.bmp_cur[6:0], 1'b0};
                end else begin
                    d.sub = q.sub + 2'd1;
                end
                if (q.phase == seg_last) begin
                    if (more) begin
                        d.phase   = '0;
                        d.sub     = '0;
                        d.col     = nxt;
                        d.bmp_cur = q.bmp_next;
                        d.fg      = fg_sel;
                        d.bg      = bg_sel;
                    end else if ((q.scale == 2'd3) && (PAD3 > 0)) begin
                        d.st    = ST_PAD;
                        d.phase = '0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: begin
                d.phase = q.phase + 1'b1;
                if (q.phase == PH_W'(PAD3 - 1)) d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.amode <= AM_NONE;
            q.scale <= 2'd1;
        end else begin
            q <= d;
        end
    end

    assign fetch_req  = q.req;
    assign fetch_attr = q.req_attr;
    assign fetch_col  = q.req_col;
    assign pix_valid  = (q.st == ST_ACT) || (q.st == ST_PAD);
    assign pix_blank  = (q.st == ST_PAD);
    assign pix_color  = (q.st == ST_ACT) ? (q.bmp_cur[7] ? q.fg : q.bg) : '0;

    // Checker counters: valid pixels and memory requests within the current line.
    logic [10:0] vcnt_q;
    logic [7:0]  fcnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt_q <= '0;
            fcnt_q <= '0;
        end else if (line_start && (q.st == ST_IDLE)) begin
            vcnt_q <= '0;
            fcnt_q <= '0;
        end else begin
            if (pix_valid) vcnt_q <= vcnt_q + 11'd1;
            if (fetch_req) fcnt_q <= fcnt_q + 8'd1;
        end
    end

    assert_line_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_valid) |-> (vcnt_q == 11'(LINE_PIX)));

    assert_blank_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_blank |-> (pix_valid && (pix_color == '0)));

    assert_no_back2back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    assert_fetch_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fcnt_q < 8'(MAX_FETCH)));

    assert_attr_in_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_attr) |-> (fetch_col < 7'(ABUF_DEPTH)));

    assert_shared_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_attr && (q.amode == AM_SHARED)) |-> !fetch_col[0]);

endmodule

// File: tb/attr_pixel_serializer_bench.sv
`timescale 1ns/100ps
module attr_pixel_serializer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic [1:0] scale_sel = 2'd0;
    logic [1:0] attr_mode = 2'd0;
    logic       first_row = 1'b0;
    logic       fetch_req, fetch_attr;
    logic [6:0] fetch_col;
    logic [7:0] fetch_data;
    logic       pix_valid, pix_blank;
    logic [3:0] pix_color;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int stored_as = 0;
    int cur_bs = 0;
    int cur_as = 0;

    always #2.5 clk = ~clk;

    attr_pixel_serializer u_attr_pixel_serializer (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .scale_sel(scale_sel),
        .attr_mode(attr_mode), .first_row(first_row), .fetch_req(fetch_req),
        .fetch_attr(fetch_attr), .fetch_col(fetch_col), .fetch_data(fetch_data),
        .pix_valid(pix_valid), .pix_blank(pix_blank), .pix_color(pix_color)
    );

    function automatic logic [7:0] bmp_val(input int seed, input int col);
        return 8'(col * 37 + seed * 53 + 91) ^ 8'(col * 5);
    endfunction

    function automatic logic [7:0] attr_val(input int seed, input int col);
        return 8'(col * 71 + seed * 29 + 17);
    endfunction

    always_comb fetch_data = fetch_attr ? attr_val(cur_as, int'(fetch_col))
                                        : bmp_val(cur_bs, int'(fetch_col));

    // Expected {blank, colour} for valid pixel p of a line.
    function automatic logic [4:0] exp_pix(input int p, input int sf, input int am,
                                           input int bs, input int sa);
        int cols, col, bi;
        logic b;
        logic [7:0] a;
        logic [3:0] nib;
        cols = 640 / (8 * sf);
        if (p >= cols * 8 * sf) return 5'b1_0000;
        col = p / (8 * sf);
        bi  = (p % (8 * sf)) / sf;
        b   = bmp_val(bs, col) >> (7 - bi);
        if (!((am == 1 || am == 2) && sf > 1)) return {1'b0, 3'b000, b};
        if (am == 1) begin
            a = attr_val(sa, col);
            return {1'b0, b ? a[7:4] : a[3:0]};
        end
        a   = attr_val(sa, col & ~1);
        nib = (col % 2 == 1) ? a[3:0] : a[7:4];
        return {1'b0, 2'b00, b ? nib[3:2] : nib[1:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_line(input logic [1:0] s, input logic [1:0] am, input logic f,
                            input int bs, input int as, input bit disturb);
        int sf, cols, exp_af, lead, nvalid, nbad, nblank, nbf, naf, badorder, oddattr;
        int first_act, first_exp;
        bit aon;
        string tag;
        logic [4:0] e;
        sf  = (s == 2'd1) ? 2 : (s == 2'd2) ? 3 : 1;
        cols = 640 / (8 * sf);
        aon = (am == 2'd1 || am == 2'd2) && sf > 1;
        if (aon && f) stored_as = as;
        exp_af = (aon && f) ? ((am == 2'd1) ? cols : (cols + 1) / 2) : 0;
        if (disturb)            tag = "R10";
        else if (!aon)          tag = (sf == 1) ? ((am != 2'd0) ? "R9" : "R2") : "R3";
        else if (!f)            tag = "R8";
        else if (am == 2'd1)    tag = "R6";
        else                    tag = "R7";
        cur_bs = bs;
        cur_as = as;
        @(negedge clk);
        line_start = 1'b1; scale_sel = s; attr_mode = am; first_row = f;
        @(negedge clk);
        line_start = 1'b0;
        lead = -1; nvalid = 0; nbad = 0; nblank = 0; nbf = 0; naf = 0;
        badorder = 0; oddattr = 0; first_act = 0; first_exp = 0;
        for (int k = 0; k < 680; k++) begin
            if (disturb && k == 100) begin
                line_start = 1'b1; scale_sel = 2'd0; attr_mode = 2'd0; first_row = ~f;
            end
            if (disturb && k == 101) begin
                line_start = 1'b0; scale_sel = s; attr_mode = am; first_row = f;
            end
            if (pix_valid) begin
                if (lead < 0) lead = k;
                e = exp_pix(nvalid, sf, am, bs, stored_as);
                if (pix_blank) nblank++;
                if (pix_color !== e[3:0] || pix_blank !== e[4]) begin
                    if (nbad == 0) begin
                        first_act = {pix_blank, pix_color};
                        first_exp = e;
                    end
                    nbad++;
                end
                nvalid++;
            end
            if (fetch_req) begin
                if (fetch_attr) begin
                    naf++;
                    if (am == 2'd2 && fetch_col[0]) oddattr++;
                end else begin
                    if (int'(fetch_col) != nbf) badorder++;
                    nbf++;
                end
            end
            @(negedge clk);
        end
        check(lead == 8, "R1", "lead-in length", lead, 8);
        check(nvalid == 640, "R1", "valid pixels per line", nvalid, 640);
        check(nbad == 0, tag, "first wrong {blank,colour}", first_act, first_exp);
        check(nblank == ((sf == 3) ? 16 : 0), "R4", "blank pixels", nblank,
              (sf == 3) ? 16 : 0);
        check(nbf == cols && badorder == 0, "R5", "bitmap requests in order", nbf, cols);
        check(naf == exp_af, (sf == 1) ? "R9" : (!f ? "R8" : tag), "attribute requests",
              naf, exp_af);
        if (am == 2'd2) check(oddattr == 0, "R7", "odd-column attribute requests", oddattr, 0);
    endtask

    // scale, attr_mode, first_row, bitmap seed, attribute seed
    localparam logic [12:0] VEC [9] = '{
        {2'd0, 2'd0, 1'b1, 4'd1,  4'd0},
        {2'd1, 2'd0, 1'b1, 4'd2,  4'd0},
        {2'd1, 2'd1, 1'b1, 4'd3,  4'd4},
        {2'd1, 2'd1, 1'b0, 4'd5,  4'd9},
        {2'd2, 2'd2, 1'b1, 4'd6,  4'd7},
        {2'd2, 2'd2, 1'b0, 4'd8,  4'd2},
        {2'd0, 2'd1, 1'b1, 4'd10, 4'd11},
        {2'd1, 2'd2, 1'b1, 4'd12, 4'd13},
        {2'd3, 2'd2, 1'b0, 4'd14, 4'd1}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs quiet while held in reset
        check(pix_valid == 1'b0 && pix_blank == 1'b0, "R11", "valid/blank in reset",
              {pix_valid, pix_blank}, 0);
        check(fetch_req == 1'b0, "R11", "fetch_req in reset", fetch_req, 0);
        check(pix_color == 4'd0, "R11", "pix_color in reset", pix_color, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            run_line(VEC[i][12:11], VEC[i][10:9], VEC[i][8],
                     int'(VEC[i][7:4]), int'(VEC[i][3:0]), 1'b0);
        end

        // R10: restart pulse and mode changes mid-line have no effect
        run_line(2'd2, 2'd1, 1'b1, 3, 6, 1'b1);

        // R11: reset in the middle of a line
        @(negedge clk);
        line_start = 1'b1; scale_sel = 2'd1; attr_mode = 2'd0; first_row = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(pix_valid == 1'b0 && fetch_req == 1'b0 && pix_color == 4'd0, "R11",
              "outputs after mid-line reset", {pix_valid, fetch_req, pix_color}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_line(2'd1, 2'd0, 1'b1, 9, 0, 1'b0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule